// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer Bank

This block holds a set of independent up-counting timer channels behind one register read/write port. Each channel has a control register, a clock configuration register, a counter that can be read at any time, and a compare register. When an enabled counter reaches its compare value, the channel raises a pending flag. The channel's run mode then decides what happens next: the counter restarts from zero (repeat), the channel stops itself (one-shot), or the counter keeps going (free-running).

Each channel counts either on every cycle of the system clock or on a single-cycle slow-tick enable input. Either source can be halved by an optional divide-by-two. One interrupt-enable register and one write-1-to-clear acknowledge register serve all channels. Channel n owns bit n-1 of both. The single interrupt output is asserted while any channel has both its pending flag and its enable bit set. To reprogram a channel, software first disables it. It then writes the compare value and acknowledges the channel's interrupt. Finally it writes the mode, enable and clear bits together in one control write.

The register port is a plain write strobe with address and data. The read path is combinational from the address. Address bits [7:4] pick a window: 0 is the global window, and 1 to 6 are the channels. Bits [3:2] pick the register inside that window.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0, every counter reads 0 and `irq` is low.
- R2: On the system-clock source with no divider, an enabled counter adds 1 on every clock edge. A disabled counter holds its value.
- R3: Writing control bit 1 as 1 makes the counter read 0 right after that write's edge, and the divider phase restarts. Control bit 1 always reads back 0, while bit 0 (enable) and bits [5:4] (mode) read back as written.
- R4: A match happens when the counter advances while it equals the compare value. In repeat mode (mode 1) a match sets the channel's pending flag and loads 0, so the period is compare+1 advances.
- R5: In one-shot mode (mode 0, and also the unused mode 2), a match sets the pending flag, clears the enable bit and leaves the counter at the compare value.
- R6: In free-running mode (mode 3), a match sets the pending flag and the counter keeps adding 1, wrapping naturally at its width.
- R7: With clock register bit 4 set, a counter advances only on edges where `tick_slow` is high.
- R8: With clock register bit 0 set, a counter advances on every second qualifying source tick, and the first advance after a clear comes on the second tick.
- R9: The interrupt-enable register sits at 0x00, with bit n-1 for channel n. `irq` equals the OR over all channels of pending AND enable.
- R10: The acknowledge register at 0x08 is write-1-to-clear on bit n-1 for channel n, and zero bits in the write have no effect. Writing 0x3F clears every pending flag, and reading 0x08 returns the pending flags. A match in the same cycle as an acknowledge wins.
- R11: Channel n's control register is at 0x10*n, its clock register at 0x04+0x10*n, its counter at 0x08+0x10*n and its compare register at 0x0C+0x10*n. Addresses outside this map read 0.
- R12: The counter register is read-only, and a write to it leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Single-cycle enable from the slow time base |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong counter or divider phase shows up directly in the counter register. A counting error is visible on the first edge after the bad advance, and a phase error within two source ticks. A missed or extra match shows in the acknowledge register's pending bits one edge after the compare value is reached. For a one-shot channel, it also shows as the enable bit dropping in the control register. A pending flag that is lost, or that fails to clear, shows on `irq` in the same cycle once that channel's interrupt enable is set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE   = 2'd0,
      MODE_REPEAT = 2'd1,
      MODE_RSVD   = 2'd2,
      MODE_FREE   = 2'd3
   } run_mode_e;

   // control register fields
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_CLR_BIT  = 1;
   localparam int CTRL_MODE_LSB = 4;

   // clock register fields
   localparam int CKCFG_DIV_BIT = 0;
   localparam int CKCFG_SRC_BIT = 4;

   // register slot inside a 16-byte window, address bits [3:2]
   localparam logic [1:0] SLOT_CTRL = 2'd0;
   localparam logic [1:0] SLOT_CKCFG = 2'd1;
   localparam logic [1:0] SLOT_CNT  = 2'd2;
   localparam logic [1:0] SLOT_CMP  = 2'd3;

   // global window slots
   localparam logic [1:0] SLOT_IEN  = 2'd0;
   localparam logic [1:0] SLOT_ACK  = 2'd2;

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              ctrl_we,
   input  logic              ckcfg_we,
   input  logic              cmp_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] ckcfg_rd,
   output logic [DATA_W-1:0] cnt_rd,
   output logic [DATA_W-1:0] cmp_rd,
   output logic              hit,
   output logic              en_o,
   output logic              clr_o,
   output logic [1:0]        mode_o,
   output logic [CNT_W-1:0]  cnt_o
);

   logic             en_q;
   run_mode_e        mode_q;
   logic             src_q;
   logic             div_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic             clr;
   logic             src_tick;
   logic             adv;
   logic             stop_mode;

   assign clr       = ctrl_we & wdata[CTRL_CLR_BIT];
   assign src_tick  = en_q & (src_q ? tick_slow : 1'b1);
   assign hit       = adv & (cnt_q == cmp_q);
   assign stop_mode = (mode_q != MODE_REPEAT) && (mode_q != MODE_FREE);

   generate
      if (HAS_DIV) begin : g_div
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase_q <= 1'b0;
            else if (clr)              phase_q <= 1'b0;
            else if (src_tick && div_q) phase_q <= ~phase_q;
         end
         assign adv = src_tick & (~div_q | phase_q);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = div_q;
         assign adv = src_tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= MODE_ONCE;
      end else if (ctrl_we) begin
         en_q   <= wdata[CTRL_EN_BIT];
         mode_q <= run_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
      end else if (hit && stop_mode) begin
         en_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= 1'b0;
      end else if (ckcfg_we) begin
         src_q <= wdata[CKCFG_SRC_BIT];
         div_q <= HAS_DIV ? wdata[CKCFG_DIV_BIT] : 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (cmp_we) cmp_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (adv) begin
         if (hit && mode_q == MODE_REPEAT) cnt_q <= '0;
         else if (!(hit && stop_mode))     cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      ctrl_rd                        = '0;
      ctrl_rd[CTRL_EN_BIT]           = en_q;
      ctrl_rd[CTRL_MODE_LSB +: 2]    = mode_q;
      ckcfg_rd                       = '0;
      ckcfg_rd[CKCFG_SRC_BIT]        = src_q;
      ckcfg_rd[CKCFG_DIV_BIT]        = div_q;
   end

   assign cnt_rd = DATA_W'(cnt_q);
   assign cmp_rd = DATA_W'(cmp_q);
   assign en_o   = en_q;
   assign clr_o  = clr;
   assign mode_o = mode_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_we,
   input  logic              ack_we,
   input  logic [NUM_CH-1:0] wbits,
   input  logic [NUM_CH-1:0] hit,
   output logic [NUM_CH-1:0] ien_o,
   output logic [NUM_CH-1:0] pend_o,
   output logic              irq
);

   logic [NUM_CH-1:0] ien_q;
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] ack_mask;

   assign ack_mask = ack_we ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_we) ien_q <= wbits;
   end

   // a match in the acknowledge cycle is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack_mask) | hit;
   end

   assign irq    = |(pend_q & ien_q);
   assign ien_o  = ien_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int WIN_W  = ADDR_W - 4;
   localparam int MAX_CH = (1 << WIN_W) - 1;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("tmr_bank: NUM_CH does not fit the address windows");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tmr_bank: CNT_W must be 1..DATA_W");
      end
      if (DATA_W < 8 || DATA_W < NUM_CH) begin : g_bad_data
         $error("tmr_bank: DATA_W too narrow for the register fields");
      end
   endgenerate

   logic [WIN_W-1:0] win;
   logic [1:0]       slot;
   logic [1:0]       unused_lsb;

   assign win        = bus_addr[ADDR_W-1:4];
   assign slot       = bus_addr[3:2];
   assign unused_lsb = bus_addr[1:0];

   logic [NUM_CH-1:0]             ctrl_we_all;
   logic [NUM_CH-1:0]             ckcfg_we_all;
   logic [NUM_CH-1:0]             cmp_we_all;
   logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd;
   logic [NUM_CH-1:0][DATA_W-1:0] ckcfg_rd;
   logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd;
   logic [NUM_CH-1:0][DATA_W-1:0] cmp_rd;
   logic [NUM_CH-1:0]             hit_all;
   logic [NUM_CH-1:0]             en_all;
   logic [NUM_CH-1:0]             clr_all;
   logic [NUM_CH-1:0][1:0]        mode_all;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
   logic [NUM_CH-1:0]             ien_all;
   logic [NUM_CH-1:0]             pend_all;
   logic                          glb_sel;
   logic                          ien_we;
   logic                          ack_we;

   assign glb_sel = (win == '0);
   assign ien_we  = bus_wr & glb_sel & (slot == SLOT_IEN);
   assign ack_we  = bus_wr & glb_sel & (slot == SLOT_ACK);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic sel;
         assign sel             = bus_wr & (win == WIN_W'(i + 1));
         assign ctrl_we_all[i]  = sel & (slot == SLOT_CTRL);
         assign ckcfg_we_all[i] = sel & (slot == SLOT_CKCFG);
         assign cmp_we_all[i]   = sel & (slot == SLOT_CMP);

         tmr_chan #(
            .CNT_W   (CNT_W),
            .DATA_W  (DATA_W),
            .HAS_DIV (HAS_DIV)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_slow(tick_slow),
            .ctrl_we  (ctrl_we_all[i]),
            .ckcfg_we (ckcfg_we_all[i]),
            .cmp_we   (cmp_we_all[i]),
            .wdata    (bus_wdata),
            .ctrl_rd  (ctrl_rd[i]),
            .ckcfg_rd (ckcfg_rd[i]),
            .cnt_rd   (cnt_rd[i]),
            .cmp_rd   (cmp_rd[i]),
            .hit      (hit_all[i]),
            .en_o     (en_all[i]),
            .clr_o    (clr_all[i]),
            .mode_o   (mode_all[i]),
            .cnt_o    (cnt_all[i])
         );
      end
   endgenerate

   tmr_irq #(
      .NUM_CH(NUM_CH)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ien_we (ien_we),
      .ack_we (ack_we),
      .wbits  (bus_wdata[NUM_CH-1:0]),
      .hit    (hit_all),
      .ien_o  (ien_all),
      .pend_o (pend_all),
      .irq    (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (glb_sel) begin
         if (slot == SLOT_IEN)      bus_rdata[NUM_CH-1:0] = ien_all;
         else if (slot == SLOT_ACK) bus_rdata[NUM_CH-1:0] = pend_all;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (win == WIN_W'(i + 1)) begin
            case (slot)
               SLOT_CTRL:  bus_rdata = ctrl_rd[i];
               SLOT_CKCFG: bus_rdata = ckcfg_rd[i];
               SLOT_CNT:   bus_rdata = cnt_rd[i];
               default:    bus_rdata = cmp_rd[i];
            endcase
         end
      end
   end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
   parameter int NUM_CH = 6,
   parameter int CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         irq,
   input logic                         ack_we,
   input logic [NUM_CH-1:0]            ack_bits,
   input logic [NUM_CH-1:0]            hit_all,
   input logic [NUM_CH-1:0]            pend_all,
   input logic [NUM_CH-1:0]            ien_all,
   input logic [NUM_CH-1:0]            en_all,
   input logic [NUM_CH-1:0]            clr_all,
   input logic [NUM_CH-1:0]            ctrl_we_all,
   input logic [NUM_CH-1:0][1:0]       mode_all,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);

   a_r9_quiet_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_all == '0) |-> !irq);

   a_r9_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_all == '0) |-> !irq);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         a_r4_match_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            hit_all[i] |=> pend_all[i]);

         a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && ack_bits[i] && !hit_all[i]) |=> !pend_all[i]);

         a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_all[i] && !(ack_we && ack_bits[i])) |=> pend_all[i]);

         a_r2_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_all[i] && !clr_all[i]) |=> $stable(cnt_all[i]));

         a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all[i] |=> (cnt_all[i] == '0));

         a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_all[i] && mode_all[i] == 2'd0 && !ctrl_we_all[i])
            |=> (!en_all[i] && $stable(cnt_all[i])));
      end
   endgenerate

endmodule

bind tmr_bank tmr_bank_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .ack_we     (ack_we),
   .ack_bits   (bus_wdata[NUM_CH-1:0]),
   .hit_all    (hit_all),
   .pend_all   (pend_all),
   .ien_all    (ien_all),
   .en_all     (en_all),
   .clr_all    (clr_all),
   .ctrl_we_all(ctrl_we_all),
   .mode_all   (mode_all),
   .cnt_all    (cnt_all)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr_bank u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_slow(tick_slow),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   typedef struct packed {
      logic [3:0]  ch;
      logic [1:0]  mode;
      logic [31:0] cmp;
      logic [7:0]  n;
      logic [31:0] cnt;
      logic        pend;
   } vec_t;

   // channel, mode, compare, edges run, expected counter, expected pending
   localparam vec_t VECS [8] = '{
      '{4'd1, 2'd3, 32'd100, 8'd10, 32'd10, 1'b0},
      '{4'd2, 2'd1, 32'd3,   8'd4,  32'd0,  1'b1},
      '{4'd3, 2'd1, 32'd3,   8'd6,  32'd2,  1'b1},
      '{4'd4, 2'd0, 32'd5,   8'd5,  32'd5,  1'b0},
      '{4'd4, 2'd0, 32'd5,   8'd9,  32'd5,  1'b1},
      '{4'd5, 2'd3, 32'd2,   8'd7,  32'd7,  1'b1},
      '{4'd6, 2'd1, 32'd0,   8'd3,  32'd0,  1'b1},
      '{4'd1, 2'd0, 32'd0,   8'd4,  32'd0,  1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // disable, configure clock, compare, acknowledge all, then mode+enable+clear
   task automatic prog(input int ch, input logic [1:0] mode, input logic [31:0] cmp,
                       input logic [31:0] ckcfg);
      wr(8'(16 * ch), 32'h0);
      wr(8'(16 * ch + 4), ckcfg);
      wr(8'(16 * ch + 12), cmp);
      wr(8'h08, 32'h3F);
      wr(8'(16 * ch), {26'd0, mode, 4'b0011});
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] c;
      string tag;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, d); chk("R1 ien reset", d, 32'h0);
      rd(8'h08, d); chk("R1 pending reset", d, 32'h0);
      rd(8'h10, d); chk("R1 ctrl reset", d, 32'h0);
      rd(8'h18, d); chk("R1 counter reset", d, 32'h0);
      rd(8'h6C, d); chk("R1 compare reset", d, 32'h0);
      chk("R1 irq reset", {31'd0, irq}, 32'h0);

      // table of run-mode vectors on the system clock
      for (int v = 0; v < 8; v++) begin
         vec_t e;
         int ch;
         e  = VECS[v];
         ch = int'(e.ch);
         prog(ch, e.mode, e.cmp, 32'h0);
         repeat (int'(e.n)) @(negedge clk);
         tag = (e.mode == 2'd3) ? "R6" : (e.mode == 2'd1) ? "R4" : "R5";
         rd(8'(16 * ch + 8), d);
         chk($sformatf("%s R2 counter vec%0d", tag, v), d, e.cnt);
         rd(8'h08, d);
         chk($sformatf("%s pending vec%0d", tag, v), {31'd0, d[ch-1]}, {31'd0, e.pend});
         rd(8'(16 * ch), d);
         chk($sformatf("%s ctrl vec%0d", tag, v), d,
             {26'd0, e.mode, 3'b000, (e.mode == 2'd0) ? ~e.pend : 1'b1});
         wr(8'(16 * ch), 32'h0);
      end

      // R2 disabled counter holds
      prog(2, 2'd3, 32'hFFFF, 32'h0);
      repeat (5) @(negedge clk);
      wr(8'h20, 32'h30);
      rd(8'h28, c);
      repeat (6) @(negedge clk);
      rd(8'h28, d); chk("R2 disabled holds", d, c);

      // R12 counter register ignores writes
      wr(8'h28, 32'hDEAD);
      rd(8'h28, d); chk("R12 counter write ignored", d, c);

      // R3 clear bit reads back 0, enable and mode kept
      wr(8'h20, 32'h33);
      rd(8'h20, d); chk("R3 clear reads zero", d, 32'h31);
      rd(8'h28, d); chk("R3 counter cleared", d, 32'h0);
      wr(8'h20, 32'h0);

      // R7 slow tick source: 4 ticks in 10 edges
      prog(2, 2'd3, 32'hFFFF, 32'h10);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         tick_slow = (i % 3 == 0);
      end
      @(negedge clk);
      tick_slow = 1'b0;
      rd(8'h28, d); chk("R7 slow tick count", d, 32'd4);
      rd(8'h24, d); chk("R11 clock reg readback", d, 32'h10);

      // R8 divide-by-2 on slow tick: 5 ticks give 2
      prog(2, 2'd3, 32'hFFFF, 32'h11);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); tick_slow = 1'b1;
         @(negedge clk); tick_slow = 1'b0;
      end
      @(negedge clk);
      rd(8'h28, d); chk("R8 div2 slow tick", d, 32'd2);

      // R8 divide-by-2 on system clock: first advance on second edge
      prog(3, 2'd3, 32'hFFFF, 32'h01);
      @(negedge clk);
      rd(8'h38, d); chk("R8 div2 first edge", d, 32'd0);
      repeat (6) @(negedge clk);
      rd(8'h38, d); chk("R8 div2 seven edges", d, 32'd3);
      wr(8'h30, 32'h0);
      wr(8'h20, 32'h0);

      // R9 / R10 interrupt enable and acknowledge
      wr(8'h08, 32'h3F);
      wr(8'h3C, 32'h0);
      wr(8'h4C, 32'h0);
      wr(8'h30, 32'h03);
      wr(8'h40, 32'h03);
      @(negedge clk);
      rd(8'h08, d); chk("R10 pending read", d, 32'h0C);
      rd(8'h30, d); chk("R5 one-shot self disable", d, 32'h0);
      chk("R9 irq masked", {31'd0, irq}, 32'h0);
      wr(8'h00, 32'h04);
      rd(8'h00, d); chk("R9 ien readback", d, 32'h04);
      chk("R9 irq on enabled pending", {31'd0, irq}, 32'h1);
      wr(8'h08, 32'h04);
      rd(8'h08, d); chk("R10 ack one bit", d, 32'h08);
      chk("R9 irq after ack", {31'd0, irq}, 32'h0);
      wr(8'h00, 32'h08);
      chk("R9 irq other channel", {31'd0, irq}, 32'h1);
      wr(8'h08, 32'h3F);
      rd(8'h08, d); chk("R10 ack all", d, 32'h0);
      chk("R10 irq cleared", {31'd0, irq}, 32'h0);

      // R11 address map
      rd(8'h3C, d); chk("R11 compare window", d, 32'h0);
      wr(8'h5C, 32'h1234);
      rd(8'h5C, d); chk("R11 compare readback", d, 32'h1234);
      rd(8'h04, d); chk("R11 unmapped global", d, 32'h0);
      rd(8'h70, d); chk("R11 unmapped window", d, 32'h0);

      done = 1'b1;
      report();
   end

endmodule